// File: doc/BRIEF.md
# Offset Trim Calibration Sequencer

This block runs the offset calibration of one analog output channel. On a start request it takes the channel offline, parks the channel's mode field at zero while remembering the old value, and raises a calibration enable toward the analog side. It then runs a successive-approximation search over a 5-bit trim code. It applies each candidate, waits a fixed settle interval, and reads a comparator flag that says whether the candidate overshoots. After the search it re-checks the final code once more, may bump it up by one, drops calibration mode and puts the saved mode back.

Outside calibration, firmware can load a trim code directly through a write port. Both that write and a finished calibration mark the trim as user-defined. The trim output always shows the code currently in force. The settle interval is set in clock cycles, computed at elaboration from the clock frequency and a settle time in microseconds.

Top module: `dac_trim_cal`

## Requirements
- R1: After reset the block is idle (`busy`, `cal_en`, `done`, `start_err` low), `trim_code` equals `RESET_TRIM` (default 0) and `trim_user` is low.
- R2: A `cal_start` while idle with `chan_busy` high is refused: in the next cycle `start_err` is high for one cycle, `busy` stays low and `trim_code` is unchanged.
- R3: A `cal_start` while idle with `chan_busy` low is taken. In the next cycle `busy` and `cal_en` are high and `trim_code` is 0x10. In that same cycle `chan_en_clr` pulses, and `mode_wr_en` pulses with `mode_wr_data` = 0. The mode value read on `mode_rd` at the start is kept.
- R4: Each candidate code stays on `trim_code` for exactly `SETTLE_N` cycles. `cmp_flag` is sampled in the last of those cycles.
- R5: The search runs with steps 8, 4, 2, 1 in turn. A high flag subtracts the current step from the code, and a low flag adds it.
- R6: After the fourth step the resulting code is sampled once more. If the flag is low and the code is below 0x1F, the code is raised by one. At 0x1F it stays.
- R7: Completion shows as a one-cycle `done` with the final code on `trim_code`. In that cycle `busy` and `cal_en` are low, `trim_user` is high, and `mode_wr_en` pulses with the saved mode on `mode_wr_data`.
- R8: A `user_wr_en` while idle (and with no accepted start) loads `user_wr_data` into `trim_code` in the next cycle and sets `trim_user`.
- R9: During a calibration, `user_wr_en` and `cal_start` have no effect: the result and the run length do not change.
- R10: `SETTLE_N` = (`CLK_HZ` / 1,000,000) × `SETTLE_US`, at least 1. A full calibration therefore raises `done` 5×`SETTLE_N`+1 cycles after the start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Calibration request |
| chan_busy | input | 1 | Channel currently converting; a start is refused |
| cmp_flag | input | 1 | Comparator result, high when the candidate overshoots |
| mode_rd | input | MODE_W | Channel mode field as currently set |
| mode_wr_en | output | 1 | One-cycle write strobe for the mode field |
| mode_wr_data | output | MODE_W | Value to write into the mode field |
| chan_en_clr | output | 1 | One-cycle request to disable the channel |
| cal_en | output | 1 | Calibration mode active on the analog side |
| user_wr_en | input | 1 | Direct trim write strobe |
| user_wr_data | input | TRIM_W | Trim code for a direct write |
| trim_code | output | TRIM_W | Trim code in force |
| trim_user | output | 1 | Trim set by user write or calibration |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| start_err | output | 1 | One-cycle refusal of a start request |

## Verification
On every cycle the assertions check several things. The code holds steady until the settle counter expires, and a refused start never raises `busy`. An accepted start presents mid-scale together with the channel-disable and mode-clear strobes. `done` lasts one cycle and coincides with an idle, user-marked trim, and writes made mid-run leave the code alone. Only the bench scenarios can show that the search actually converges to the right code for a given comparator threshold. The same holds for the verify step adding one only below full scale, for the saved mode coming back unchanged, and for the total run length matching the settle parameter.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_VERIFY = 2'd2
    } cal_state_e;

    // Cycles per settle interval, never below one.
    function automatic int unsigned settle_cycles(longint unsigned clk_hz,
                                                  int unsigned     us);
        longint unsigned c;
        c = (clk_hz / 64'd1_000_000) * us;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/dac_trim_settle.sv
module dac_trim_settle #(
    parameter int unsigned CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic expired
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || clr) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && (cnt_q == LAST);

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R4

endmodule

// File: rtl/dac_trim_sar.sv
module dac_trim_sar #(
    parameter int unsigned TRIM_W = 5
) (
    input  logic [TRIM_W-1:0] code,
    input  logic [TRIM_W-1:0] step,
    input  logic              flag,
    output logic [TRIM_W-1:0] code_next,
    output logic [TRIM_W-1:0] step_next,
    output logic              last,
    output logic [TRIM_W-1:0] verify_code
);
    localparam logic [TRIM_W-1:0] MAX_CODE = {TRIM_W{1'b1}};

    always_comb begin
        code_next = flag ? (code - step) : (code + step);
        step_next = step >> 1;
        last      = (step == TRIM_W'(1));
        if (!flag && (code != MAX_CODE)) verify_code = code + 1'b1;
        else                             verify_code = code;
    end

endmodule

// File: rtl/dac_trim_cal.sv
module dac_trim_cal
    import dac_trim_pkg::*;
#(
    parameter int unsigned     TRIM_W     = 5,
    parameter int unsigned     MODE_W     = 3,
    parameter longint unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned     SETTLE_US  = 50,
    parameter int unsigned     RESET_TRIM = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              chan_busy,
    input  logic              cmp_flag,
    input  logic [MODE_W-1:0] mode_rd,
    output logic              mode_wr_en,
    output logic [MODE_W-1:0] mode_wr_data,
    output logic              chan_en_clr,
    output logic              cal_en,
    input  logic              user_wr_en,
    input  logic [TRIM_W-1:0] user_wr_data,
    output logic [TRIM_W-1:0] trim_code,
    output logic              trim_user,
    output logic              busy,
    output logic              done,
    output logic              start_err
);
    localparam int unsigned       SETTLE_N   = settle_cycles(CLK_HZ, SETTLE_US);
    localparam logic [TRIM_W-1:0] MID_CODE   = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [TRIM_W-1:0] FIRST_STEP = TRIM_W'(1) << (TRIM_W - 2);

    typedef struct packed {
        cal_state_e        st;
        logic [TRIM_W-1:0] trim;
        logic [TRIM_W-1:0] step;
        logic [MODE_W-1:0] saved;
        logic              user;
        logic              done;
        logic              err;
        logic              mode_we;
        logic [MODE_W-1:0] mode_wd;
        logic              ch_clr;
    } regs_t;

    regs_t r_d, r_q;

    logic              expired;
    logic [TRIM_W-1:0] code_next, step_next, verify_code;
    logic              last_step;

    dac_trim_settle #(.CYCLES(SETTLE_N)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (r_q.st != ST_IDLE),
        .clr     (expired),
        .expired (expired)
    );

    dac_trim_sar #(.TRIM_W(TRIM_W)) u_sar (
        .code        (r_q.trim),
        .step        (r_q.step),
        .flag        (cmp_flag),
        .code_next   (code_next),
        .step_next   (step_next),
        .last        (last_step),
        .verify_code (verify_code)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        r_d.mode_we = 1'b0;
        r_d.ch_clr  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cal_start && !chan_busy) begin
                    r_d.st      = ST_SEARCH;
                    r_d.trim    = MID_CODE;
                    r_d.step    = FIRST_STEP;
                    r_d.saved   = mode_rd;
                    r_d.mode_we = 1'b1;
                    r_d.mode_wd = '0;
                    r_d.ch_clr  = 1'b1;
                end else begin
                    r_d.err = cal_start;
                    if (user_wr_en) begin
                        r_d.trim = user_wr_data;
                        r_d.user = 1'b1;
                    end
                end
            end
            ST_SEARCH: begin
                if (expired) begin
                    r_d.trim = code_next;
                    r_d.step = step_next;
                    if (last_step) r_d.st = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (expired) begin
                    r_d.trim    = verify_code;
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.user    = 1'b1;
                    r_d.mode_we = 1'b1;
                    r_d.mode_wd = r_q.saved;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.trim    <= TRIM_W'(RESET_TRIM);
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign cal_en       = busy;
    assign trim_code    = r_q.trim;
    assign trim_user    = r_q.user;
    assign done         = r_q.done;
    assign start_err    = r_q.err;
    assign mode_wr_en   = r_q.mode_we;
    assign mode_wr_data = r_q.mode_wd;
    assign chan_en_clr  = r_q.ch_clr;

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expired) |=> $stable(trim_code));  // R4
    AST_REJECT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cal_start && chan_busy) |=> (start_err && !busy));  // R2
    AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cal_start && !chan_busy) |=> (busy && chan_en_clr && mode_wr_en
            && (mode_wr_data == '0) && (trim_code == MID_CODE)));  // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cal_en && trim_user && mode_wr_en));  // R7
    AST_USER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && user_wr_en && !expired) |=> $stable(trim_code));  // R9

endmodule

// File: tb/dac_trim_cal_test.sv
`timescale 1ns/1ps
module dac_trim_cal_test;
    localparam int TW   = 5;
    localparam int MW   = 3;
    localparam int SN   = 12;   // 4 MHz x 3 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0, chan_busy = 1'b0, user_wr_en = 1'b0;
    logic [TW-1:0] user_wr_data = '0;
    logic cmp_flag;
    logic [MW-1:0] mode_rd, mode_wr_data;
    logic mode_wr_en, chan_en_clr, cal_en, trim_user, busy, done, start_err;
    logic [TW-1:0] trim_code;

    int thr = 16;
    logic [MW-1:0] mode_reg = '0;
    logic mode_set = 1'b0;
    logic [MW-1:0] mode_set_val = '0;
    logic chan_en = 1'b0;
    logic en_set = 1'b0;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign cmp_flag = (int'(trim_code) >= thr);
    assign mode_rd  = mode_reg;

    always @(posedge clk) begin
        if (mode_wr_en)    mode_reg <= mode_wr_data;
        else if (mode_set) mode_reg <= mode_set_val;
        if (chan_en_clr)   chan_en <= 1'b0;
        else if (en_set)   chan_en <= 1'b1;
    end

    dac_trim_cal #(.TRIM_W(TW), .MODE_W(MW), .CLK_HZ(4_000_000),
                   .SETTLE_US(3), .RESET_TRIM(0)) uut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .chan_busy(chan_busy),
        .cmp_flag(cmp_flag), .mode_rd(mode_rd), .mode_wr_en(mode_wr_en),
        .mode_wr_data(mode_wr_data), .chan_en_clr(chan_en_clr), .cal_en(cal_en),
        .user_wr_en(user_wr_en), .user_wr_data(user_wr_data), .trim_code(trim_code),
        .trim_user(trim_user), .busy(busy), .done(done), .start_err(start_err));

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Successive approximation with comparator flag = (code >= t).
    function automatic int expect_trim(int t);
        int code = 16;
        for (int step = 8; step > 0; step = step / 2)
            code = (code >= t) ? code - step : code + step;
        if (!(code >= t) && code < 31) code++;
        return code;
    endfunction

    task automatic run_cal(int t, int mode_val, bit intrude, string tag);
        int n, run, exp;
        logic [TW-1:0] prev;
        exp = expect_trim(t);
        thr = t;
        @(negedge clk);
        mode_set = 1'b1; mode_set_val = MW'(mode_val); en_set = 1'b1;
        @(negedge clk);
        mode_set = 1'b0; en_set = 1'b0;
        cal_start = 1'b1;
        @(posedge clk); #1;
        cal_start = 1'b0;
        n = 1; run = 1; prev = trim_code;
        chk("R3 busy", int'(busy && cal_en), 1);
        chk("R3 start code", int'(trim_code), 16);
        chk("R3 strobes", int'(chan_en_clr && mode_wr_en && mode_wr_data == 0), 1);
        while (!done && n < 10 * SN + 20) begin
            @(posedge clk); #1;
            n++;
            user_wr_en = 1'b0; cal_start = 1'b0;
            if (n == 2) begin
                chk("R3 mode cleared", int'(mode_reg), 0);
                chk("R3 channel off", int'(chan_en), 0);
            end
            if (intrude && n == 5) begin
                user_wr_en = 1'b1; user_wr_data = 5'd3; cal_start = 1'b1;
            end
            if (!done) begin
                if (trim_code != prev) begin
                    chk("R4 settle length", run, SN);
                    run = 1; prev = trim_code;
                end else run++;
            end
        end
        chk("R10 run length", n, 5 * SN + 1);
        chk({tag, " final code"}, int'(trim_code), exp);
        chk("R7 done state", int'(done && !busy && !cal_en && trim_user), 1);
        @(posedge clk); #1;
        chk("R7 mode restored", int'(mode_reg), mode_val);
        chk("R7 done single", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 busy", int'(busy), 0);
        chk("R1 trim", int'(trim_code), 0);
        chk("R1 user", int'(trim_user), 0);
        chk("R1 done/err", int'(done || start_err || cal_en), 0);
        @(negedge clk); rst_n = 1'b1;

        // Refused start
        @(negedge clk); chan_busy = 1'b1; cal_start = 1'b1;
        @(posedge clk); #1; cal_start = 1'b0; chan_busy = 1'b0;
        chk("R2 err", int'(start_err), 1);
        chk("R2 not busy", int'(busy), 0);
        chk("R2 trim", int'(trim_code), 0);
        @(posedge clk); #1;
        chk("R2 err pulse", int'(start_err), 0);

        // User write while idle
        @(negedge clk); user_wr_en = 1'b1; user_wr_data = 5'd7;
        @(posedge clk); #1; user_wr_en = 1'b0;
        chk("R8 trim", int'(trim_code), 7);
        chk("R8 user", int'(trim_user), 1);

        // Directed thresholds
        run_cal(16, 5, 0, "R6 verify +1");
        run_cal(0,  3, 0, "R5 all high");
        run_cal(32, 6, 0, "R6 full-scale limit");
        run_cal(31, 1, 0, "R6 top");
        run_cal(9,  2, 1, "R9 intrusion");
        // Random thresholds
        for (int i = 0; i < 8; i++)
            run_cal(int'($urandom_range(0, 32)), int'($urandom_range(0, 7)),
                    i[0], "R5 random");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule